// File: doc/BRIEF.md
# Result Store Cycle Sequencer

This block runs the write-back phase that follows instruction execution. When the execute logic pulses `start`, the sequencer latches a small set of qualifiers and the data it will need. It then steps through a chain of one-cycle steps. First it may either issue a fresh memory write or restart a paused read-modify-write cycle. After that it may store AR into the addressed fast-memory accumulator, and optionally MQ into the next accumulator. It finishes by handing control to either a console key cycle or the next instruction cycle.

The chain stops while the memory is busy. Each step that starts a memory action raises its own wait flag. A single shared completion strobe, `mem_done`, resumes the chain at the step that belongs to whichever flag is raised. Opcode decoding, the memory array and the execute datapath are outside the block. The qualifiers arrive already decoded.

Top module: `wb_store_seq`

## Requirements
- R1: On `start` with `q_fresh`=1, the first memory action is a write request (`wr_req`) at the address `ma_in` with data `mb_in`. With `q_fresh`=0 and `q_resume`=1, the first action is a restart request (`rs_req`) with the same address and data. With both at 0, no entry action occurs. Qualifiers, `ir_word`, `ar_word` and `mq_word` are latched at `start`.
- R2: After an entry action, the chain does not continue until `mem_done` is strobed. It then proceeds to the accumulator phase.
- R3: With `q_ac_inh`=1, no accumulator write is issued.
- R4: If the accumulator store is not inhibited, a write is issued with address equal to the AC field (`ir_word` bits [8:5]), all higher address bits 0, and data equal to AR.
- R5: If the accumulator store is not inhibited and `q_ac2`=1, a further write follows the first accumulator write's completion. Its address is (AC+1) mod 16, with higher bits 0, and its data is MQ. With `q_ac2`=0, no such write occurs.
- R6: At the end of the chain, if `run`=1, exactly one pulse is given: `go_key` when `key_pending`=1, otherwise `go_inst`. If `run`=0, neither pulse is given.
- R7: An AC field of 0 together with `q_self_mem`=1 inhibits the accumulator store, just as `q_ac_inh` does.
- R8: At most one wait flag is set at any time. Each `mem_done` strobe advances exactly one step, and every memory request is answered by one strobe before the next request.
- R9: Synchronous active-high reset clears all wait flags, MA and MB, and returns the sequencer to idle, including in the middle of a chain.
- R10: A `mem_done` strobe while no step is waiting has no effect: no request and no hand-off follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Execute phase finished; begin store chain |
| q_fresh | input | 1 | Write the result to memory with a new write cycle |
| q_resume | input | 1 | Complete a paused read-modify-write cycle |
| q_ac_inh | input | 1 | Inhibit the accumulator store |
| q_ac2 | input | 1 | Also store MQ into the following accumulator |
| q_self_mem | input | 1 | Self mode targeting memory (inhibits when AC is 0) |
| ir_word | input | 18 | Instruction register; AC field at bits [8:5] |
| ma_in | input | 18 | Memory address from the execute phase |
| mb_in | input | 36 | Memory buffer from the execute phase |
| ar_word | input | 36 | AR data word |
| mq_word | input | 36 | MQ data word |
| mem_done | input | 1 | Memory-cycle-complete strobe |
| run | input | 1 | Machine running |
| key_pending | input | 1 | Examine or deposit key operation pending |
| ma | output | 18 | Memory address register |
| mb | output | 36 | Memory buffer register |
| wr_req | output | 1 | Memory write request pulse |
| rs_req | output | 1 | Read-write restart request pulse |
| go_key | output | 1 | Hand-off to the console key cycle |
| go_inst | output | 1 | Hand-off to the next instruction cycle |

## Verification
The bench builds the block with its default widths: 36-bit data, an 18-bit address and a 4-bit AC field at bit 5. It sweeps all 32 combinations of the five qualifiers against AC values 0, 1, 7 and 15, and against the three run/key states. This covers every entry path, both inhibit sources, and the wrap of the second accumulator address from 15 to 0. The MA values used have high bits set, so a failure to clear those bits is visible. Separate cases cover a reset in the middle of a chain and a stray completion strobe.

// File: rtl/wb_store_pkg.sv
package wb_store_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FRESH,
        ST_RESUME,
        ST_WAIT,
        ST_ACSEL,
        ST_ACGAP,
        ST_ACWR,
        ST_ACDONE,
        ST_AC2WR,
        ST_FINAL
    } step_e;

    typedef enum logic [2:0] {
        MA_KEEP,
        MA_TAKE,
        MA_ZERO,
        MA_ORAC,
        MA_BUMP
    } ma_op_e;

    typedef enum logic [1:0] {
        MB_KEEP,
        MB_TAKE,
        MB_AR,
        MB_MQ
    } mb_op_e;

    typedef struct packed {
        logic fresh;
        logic resume;
        logic ac_inh;
        logic ac2;
        logic self_mem;
    } qual_t;

    typedef struct packed {
        ma_op_e ma_op;
        mb_op_e mb_op;
        logic   capture;
    } dp_cmd_t;

    localparam int WF_ENTRY = 0;
    localparam int WF_AC1   = 1;
    localparam int WF_AC2   = 2;
    localparam int NUM_WF   = 3;

    // R3 R7: accumulator store blocked by explicit inhibit or self mode on AC 0
    function automatic logic ac_store_blocked(input qual_t q, input logic ac_zero);
        return q.ac_inh || (ac_zero && q.self_mem);
    endfunction

endpackage

// File: rtl/wb_store_regs.sv
module wb_store_regs
    import wb_store_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 18,
    parameter int AC_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  dp_cmd_t           cmd,
    input  logic [AC_W-1:0]   ac_in,
    input  logic [ADDR_W-1:0] ma_in,
    input  logic [DATA_W-1:0] mb_in,
    input  logic [DATA_W-1:0] ar_in,
    input  logic [DATA_W-1:0] mq_in,
    output logic [ADDR_W-1:0] ma,
    output logic [DATA_W-1:0] mb
);

    logic [AC_W-1:0]   ac_q;
    logic [DATA_W-1:0] ar_q;
    logic [DATA_W-1:0] mq_q;
    logic [AC_W-1:0]   ac_next;

    // R5: fast-memory index wraps within 2**AC_W locations
    assign ac_next = ma[AC_W-1:0] + AC_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q <= '0;
            ar_q <= '0;
            mq_q <= '0;
        end else if (cmd.capture) begin
            ac_q <= ac_in;
            ar_q <= ar_in;
            mq_q <= mq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ma <= '0;
        end else begin
            unique case (cmd.ma_op)
                MA_TAKE: ma <= ma_in;
                MA_ZERO: ma <= '0;
                MA_ORAC: ma <= ma | ADDR_W'(ac_q);   // R4
                MA_BUMP: ma <= ADDR_W'(ac_next);     // R5
                default: ma <= ma;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mb <= '0;
        end else begin
            unique case (cmd.mb_op)
                MB_TAKE: mb <= mb_in;
                MB_AR:   mb <= ar_q;
                MB_MQ:   mb <= mq_q;
                default: mb <= mb;
            endcase
        end
    end

endmodule

// File: rtl/wb_store_ctrl.sv
module wb_store_ctrl
    import wb_store_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  qual_t             qual,
    input  logic              ac_zero,
    input  logic              mem_done,
    input  logic              run,
    input  logic              key_pending,
    output dp_cmd_t           cmd,
    output logic              wr_req,
    output logic              rs_req,
    output logic              go_key,
    output logic              go_inst,
    output logic [NUM_WF-1:0] wait_flags
);

    step_e state;
    logic  ac2_q;
    logic  blocked_q;

    // Datapath command for the step executing at this edge
    always_comb begin
        cmd.ma_op   = MA_KEEP;
        cmd.mb_op   = MB_KEEP;
        cmd.capture = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    cmd.ma_op   = MA_TAKE;
                    cmd.mb_op   = MB_TAKE;
                    cmd.capture = 1'b1;
                end
            end
            ST_ACSEL: begin
                if (!blocked_q) cmd.ma_op = MA_ZERO;
            end
            ST_ACWR: begin
                cmd.ma_op = MA_ORAC;
                cmd.mb_op = MB_AR;
            end
            ST_AC2WR: begin
                cmd.ma_op = MA_BUMP;
                cmd.mb_op = MB_MQ;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            // R9
            state      <= ST_IDLE;
            wait_flags <= '0;
            ac2_q      <= 1'b0;
            blocked_q  <= 1'b0;
            wr_req     <= 1'b0;
            rs_req     <= 1'b0;
            go_key     <= 1'b0;
            go_inst    <= 1'b0;
        end else begin
            wr_req  <= 1'b0;
            rs_req  <= 1'b0;
            go_key  <= 1'b0;
            go_inst <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    // R10: mem_done is not looked at here
                    if (start) begin
                        ac2_q     <= qual.ac2;
                        blocked_q <= ac_store_blocked(qual, ac_zero);
                        // R1: entry priority
                        if (qual.fresh)       state <= ST_FRESH;
                        else if (qual.resume) state <= ST_RESUME;
                        else                  state <= ST_ACSEL;
                    end
                end
                ST_FRESH: begin
                    wr_req               <= 1'b1;
                    wait_flags[WF_ENTRY] <= 1'b1;
                    state                <= ST_WAIT;
                end
                ST_RESUME: begin
                    rs_req               <= 1'b1;
                    wait_flags[WF_ENTRY] <= 1'b1;
                    state                <= ST_WAIT;
                end
                ST_WAIT: begin
                    // R2 R8: one strobe resumes the step owning the raised flag
                    if (mem_done) begin
                        if (wait_flags[WF_ENTRY])    state <= ST_ACSEL;
                        else if (wait_flags[WF_AC1]) state <= ST_ACDONE;
                        else if (wait_flags[WF_AC2]) state <= ST_FINAL;
                        else                         state <= ST_IDLE;
                    end
                end
                ST_ACSEL: begin
                    wait_flags[WF_ENTRY] <= 1'b0;
                    state <= blocked_q ? ST_FINAL : ST_ACGAP;
                end
                ST_ACGAP: begin
                    state <= ST_ACWR;
                end
                ST_ACWR: begin
                    wr_req             <= 1'b1;
                    wait_flags[WF_AC1] <= 1'b1;
                    state              <= ST_WAIT;
                end
                ST_ACDONE: begin
                    wait_flags[WF_AC1] <= 1'b0;
                    state <= ac2_q ? ST_AC2WR : ST_FINAL;
                end
                ST_AC2WR: begin
                    wr_req             <= 1'b1;
                    wait_flags[WF_AC2] <= 1'b1;
                    state              <= ST_WAIT;
                end
                ST_FINAL: begin
                    wait_flags[WF_AC2] <= 1'b0;
                    // R6
                    if (run) begin
                        if (key_pending) go_key  <= 1'b1;
                        else             go_inst <= 1'b1;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wb_store_seq.sv
module wb_store_seq
    import wb_store_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 18,
    parameter int IR_W   = 18,
    parameter int AC_LSB = 5,
    parameter int AC_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              q_fresh,
    input  logic              q_resume,
    input  logic              q_ac_inh,
    input  logic              q_ac2,
    input  logic              q_self_mem,
    input  logic [IR_W-1:0]   ir_word,
    input  logic [ADDR_W-1:0] ma_in,
    input  logic [DATA_W-1:0] mb_in,
    input  logic [DATA_W-1:0] ar_word,
    input  logic [DATA_W-1:0] mq_word,
    input  logic              mem_done,
    input  logic              run,
    input  logic              key_pending,
    output logic [ADDR_W-1:0] ma,
    output logic [DATA_W-1:0] mb,
    output logic              wr_req,
    output logic              rs_req,
    output logic              go_key,
    output logic              go_inst
);

    qual_t             qual;
    dp_cmd_t           cmd;
    logic [AC_W-1:0]   ac_field;
    logic              ac_zero;
    logic [NUM_WF-1:0] wait_flags;

    assign qual.fresh    = q_fresh;
    assign qual.resume   = q_resume;
    assign qual.ac_inh   = q_ac_inh;
    assign qual.ac2      = q_ac2;
    assign qual.self_mem = q_self_mem;

    // R4: AC field position
    assign ac_field = ir_word[AC_LSB +: AC_W];
    assign ac_zero  = (ac_field == '0);

    wb_store_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .qual        (qual),
        .ac_zero     (ac_zero),
        .mem_done    (mem_done),
        .run         (run),
        .key_pending (key_pending),
        .cmd         (cmd),
        .wr_req      (wr_req),
        .rs_req      (rs_req),
        .go_key      (go_key),
        .go_inst     (go_inst),
        .wait_flags  (wait_flags)
    );

    wb_store_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .AC_W   (AC_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .ac_in (ac_field),
        .ma_in (ma_in),
        .mb_in (mb_in),
        .ar_in (ar_word),
        .mq_in (mq_word),
        .ma    (ma),
        .mb    (mb)
    );

endmodule

// File: rtl/wb_store_seq_chk.sv
module wb_store_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_req,
    input logic       rs_req,
    input logic       go_key,
    input logic       go_inst,
    input logic       run,
    input logic [2:0] wait_flags
);

    // R8
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(wait_flags) <= 1);

    // R8
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && rs_req));

    // R6
    go_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(go_key && go_inst));

    // R6
    go_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        (go_key || go_inst) |-> $past(run));

    // R2
    flag_with_req_chk: assert property (@(posedge clk) disable iff (rst)
        ((wait_flags != 3'b000) && ($past(wait_flags) == 3'b000)) |-> (wr_req || rs_req));

endmodule

bind wb_store_seq wb_store_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_req     (wr_req),
    .rs_req     (rs_req),
    .go_key     (go_key),
    .go_inst    (go_inst),
    .run        (run),
    .wait_flags (wait_flags)
);

// File: tb/wb_store_seq_bench.sv
module wb_store_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        q_fresh = 1'b0, q_resume = 1'b0, q_ac_inh = 1'b0, q_ac2 = 1'b0, q_self_mem = 1'b0;
    logic [17:0] ir_word = '0;
    logic [17:0] ma_in = '0;
    logic [35:0] mb_in = '0, ar_word = '0, mq_word = '0;
    logic        mem_done = 1'b0;
    logic        run = 1'b0, key_pending = 1'b0;
    logic [17:0] ma;
    logic [35:0] mb;
    logic        wr_req, rs_req, go_key, go_inst;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // event log: kind 1 = write, 2 = restart
    int          n_ev;
    int          n_key, n_inst;
    logic [1:0]  ev_kind [4];
    logic [17:0] ev_ma   [4];
    logic [35:0] ev_mb   [4];

    always #4 clk = ~clk;

    wb_store_seq u_wb_store_seq (
        .clk(clk), .rst(rst), .start(start),
        .q_fresh(q_fresh), .q_resume(q_resume), .q_ac_inh(q_ac_inh),
        .q_ac2(q_ac2), .q_self_mem(q_self_mem),
        .ir_word(ir_word), .ma_in(ma_in), .mb_in(mb_in),
        .ar_word(ar_word), .mq_word(mq_word),
        .mem_done(mem_done), .run(run), .key_pending(key_pending),
        .ma(ma), .mb(mb), .wr_req(wr_req), .rs_req(rs_req),
        .go_key(go_key), .go_inst(go_inst)
    );

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Observe outputs at negedge, answer each request with one strobe
    task automatic observe();
        int idle = 0;
        int cd = 0;
        n_ev = 0; n_key = 0; n_inst = 0;
        while (idle < 12) begin
            @(negedge clk);
            if (mem_done) mem_done = 1'b0;
            if (wr_req || rs_req) begin
                if (n_ev < 4) begin
                    ev_kind[n_ev] = wr_req ? 2'd1 : 2'd2;
                    ev_ma[n_ev]   = ma;
                    ev_mb[n_ev]   = mb;
                end
                n_ev++;
                cd = 2;
                idle = 0;
            end else if (go_key || go_inst) begin
                if (go_key) n_key++;
                if (go_inst) n_inst++;
                idle = 0;
            end else begin
                idle++;
            end
            if (cd > 0) begin
                cd--;
                if (cd == 0) mem_done = 1'b1;
            end
        end
    endtask

    task automatic run_txn(input int q, input logic [3:0] ac, input int rk, input int idx);
        int          exp_n = 0;
        logic [1:0]  x_kind [4];
        logic [17:0] x_ma   [4];
        logic [35:0] x_mb   [4];
        string       tag [4];
        logic        blk, self_blk;
        int          xk, xi;
        @(negedge clk);
        q_fresh    = q[0];
        q_resume   = q[1];
        q_ac_inh   = q[2];
        q_ac2      = q[3];
        q_self_mem = q[4];
        ir_word    = (18'h2A01F & ~(18'hF << 5)) | (18'(ac) << 5);
        ma_in      = 18'h3F0F0 ^ 18'(idx);
        mb_in      = 36'h123456789 + 36'(idx);
        ar_word    = 36'h5A5A50000 ^ 36'(idx);
        mq_word    = 36'hC3C3C3C3C ^ (36'(idx) << 3);
        run        = (rk != 0);
        key_pending = (rk == 2);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        q_fresh = 1'b0; q_resume = 1'b0; q_ac_inh = 1'b0; q_ac2 = 1'b0; q_self_mem = 1'b0;
        ir_word = '0; ar_word = '0; mq_word = '0;
        observe();

        self_blk = (ac == 4'd0) && q[4];
        blk = q[2] || self_blk;
        if (q[0] || q[1]) begin
            x_kind[0] = q[0] ? 2'd1 : 2'd2;
            x_ma[0] = 18'h3F0F0 ^ 18'(idx);
            x_mb[0] = 36'h123456789 + 36'(idx);
            tag[0] = "R1";
            exp_n = 1;
        end
        if (!blk) begin
            x_kind[exp_n] = 2'd1;
            x_ma[exp_n] = 18'(ac);
            x_mb[exp_n] = 36'h5A5A50000 ^ 36'(idx);
            tag[exp_n] = (exp_n == 1) ? "R2" : "R4";
            exp_n++;
            if (q[3]) begin
                x_kind[exp_n] = 2'd1;
                x_ma[exp_n] = 18'(4'(ac + 4'd1));
                x_mb[exp_n] = 36'hC3C3C3C3C ^ (36'(idx) << 3);
                tag[exp_n] = "R5";
                exp_n++;
            end
        end
        chk(n_ev == exp_n, self_blk && !q[2] ? "R7" : (q[2] ? "R3" : "R8"),
            "request count", 64'(n_ev), 64'(exp_n));
        if (n_ev == exp_n) begin
            for (int i = 0; i < exp_n; i++) begin
                chk(ev_kind[i] == x_kind[i], tag[i], "request kind", 64'(ev_kind[i]), 64'(x_kind[i]));
                chk(ev_ma[i] == x_ma[i], tag[i], "address", 64'(ev_ma[i]), 64'(x_ma[i]));
                chk(ev_mb[i] == x_mb[i], tag[i], "data", 64'(ev_mb[i]), 64'(x_mb[i]));
            end
        end
        xk = (rk == 2) ? 1 : 0;
        xi = (rk == 1) ? 1 : 0;
        chk(n_key == xk && n_inst == xi, "R6", "handoff key/inst",
            64'({n_key[15:0], n_inst[15:0]}), 64'({xk[15:0], xi[15:0]}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(!wr_req && !rs_req && !go_key && !go_inst, "R9", "reset pulses",
            64'({wr_req, rs_req, go_key, go_inst}), 64'(0));
        chk(ma == '0 && mb == '0, "R9", "reset ma/mb", 64'(ma), 64'(0));

        // R10: stray strobe while idle
        mem_done = 1'b1;
        @(negedge clk);
        mem_done = 1'b0;
        observe();
        chk(n_ev == 0 && n_key == 0 && n_inst == 0, "R10", "stray strobe activity",
            64'(n_ev + n_key + n_inst), 64'(0));

        // R9: reset in the middle of a chain
        @(negedge clk);
        q_fresh = 1'b1; q_ac2 = 1'b1; ir_word = 18'(4'd3) << 5;
        ma_in = 18'h3FFFF; mb_in = 36'hFFFFFFFFF;
        run = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; q_fresh = 1'b0; q_ac2 = 1'b0;
        while (!wr_req) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(ma == '0 && mb == '0 && !wr_req, "R9", "mid-chain reset regs",
            64'(ma), 64'(0));
        mem_done = 1'b1;
        @(negedge clk);
        mem_done = 1'b0;
        observe();
        chk(n_ev == 0 && n_key == 0 && n_inst == 0, "R9", "after mid-chain reset activity",
            64'(n_ev + n_key + n_inst), 64'(0));

        // Sweep: qualifiers x AC values x run/key states (R1..R8)
        begin
            int idx = 0;
            for (int q = 0; q < 32; q++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int rk = 0; rk < 3; rk++) begin
                        logic [3:0] acv;
                        acv = (a == 0) ? 4'd0 : (a == 1) ? 4'd1 : (a == 2) ? 4'd7 : 4'd15;
                        run_txn(q, acv, rk, idx);
                        idx++;
                    end
                end
            end
        end
        summary_and_end();
    end

endmodule